// File: doc/BRIEF.md
# PWM Channel with Latched Trigger Clear

This block is a single timer compare channel. An up-counter runs from zero to a programmable top value and then wraps, and it flags an update event in the wrap cycle. A compare value and a 3-bit mode select turn the counter into a reference waveform. The modes are a PWM level, an output-compare action taken on a match, or a forced constant level.

An external trigger input first passes through a polarity select, a sampling register and a run-length filter. When the channel's clear enable is set and the filtered trigger is active, the reference is pulled low at once. It then stays low until the next update event, whatever the trigger does after that. If the trigger is still active at that update event, the hold starts again at once. This gives a cycle-by-cycle limit: a comparator on a current sense can cut the present PWM pulse, and the next period starts normally. The forced modes do not respond to the trigger.

The configuration inputs are meant to be set up while the block is in reset, or left steady while it runs. `rst_n` is asserted asynchronously and must be released in step with `clk`.

Top module: `pwmclr_channel`

## Requirements
- R1: After reset the counter goes up by one on each clock while `cnt_en_i` is 1. It returns to 0 on the clock after it equals `arr_i`. `upd_o` is 1 exactly when `cnt_en_i` is 1 and the counter equals `arr_i`. While `cnt_en_i` is 0 the counter holds and `upd_o` is 0.
- R2: Mode code 6 (PWM1) gives a reference of 1 while counter < `ccr_i`, and 0 otherwise. Mode code 7 (PWM2) gives the inverse. In PWM1, a compare value above `arr_i` keeps the reference at 1, and a compare value of 0 keeps it at 0.
- R3: The output-compare modes act on the clock edge at which the running counter equals `ccr_i`, so the new level appears in the counter's next state. Code 1 sets the level, code 2 clears it, code 3 toggles it, and code 0 (frozen) holds it.
- R4: Code 4 forces the reference to 0 and code 5 forces it to 1. In these modes the trigger clear has no effect.
- R5: When `clr_en_i` is 1 and the filtered trigger is active, the reference is 0. With a filter length of 1 this is visible after the second clock edge following the input change: one sampling edge, then one filter edge.
- R6: After the trigger has caused a clear, the reference stays 0 after the trigger goes inactive. It is released only by the next update event.
- R7: If the filtered trigger is still active in the update-event cycle, the hold is set again. The reference then stays 0 for the whole next period.
- R8: When `clr_en_i` is 0, the trigger does not change the reference.
- R9: With `trig_pol_i` = 0 the trigger is active high. With `trig_pol_i` = 1 it is active low.
- R10: `flt_sel_i` values 0, 1, 2 and 3 select a filter length N of 1, 2, 4 or 8. The filtered level takes a new value only after N consecutive samples that disagree with it. A pulse shorter than N clocks is ignored. A pulse of N clocks takes effect 1+N clocks after it starts.
- R11: While `rst_n` is 0, the counter, the output-compare level, the hold and the filter state are all 0. So `upd_o` is 0 when `arr_i` > 0, and the output-compare modes drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Counter enable |
| arr_i | input | CNT_W | Counter top value (period is arr_i+1) |
| ccr_i | input | CNT_W | Compare value |
| mode_i | input | 3 | Reference mode code |
| clr_en_i | input | 1 | Trigger clear enable |
| trig_pol_i | input | 1 | Trigger polarity (1 = active low) |
| flt_sel_i | input | 2 | Trigger filter length select |
| trig_i | input | 1 | External trigger |
| ref_o | output | 1 | Output reference |
| upd_o | output | 1 | Update event, one clock per wrap |

## Verification
The counter's update event and an active filtered trigger can fall in the same cycle. In that cycle, releasing the hold and setting it again compete for one register. The bench holds the trigger active across a wrap. It then requires the reference to stay 0 through the whole next period, even after the trigger is dropped just after the wrap, and to rise only at the wrap after that. The bench also drops the trigger well before a wrap, and there it requires the reference to rise exactly in the first cycle of the new period.

// File: rtl/pwmclr_pkg.sv
package pwmclr_pkg;
  typedef enum logic [2:0] {
    MODE_FROZEN = 3'd0,
    MODE_SET    = 3'd1,
    MODE_CLR    = 3'd2,
    MODE_TOGGLE = 3'd3,
    MODE_FLOW   = 3'd4,
    MODE_FHIGH  = 3'd5,
    MODE_PWM1   = 3'd6,
    MODE_PWM2   = 3'd7
  } ref_mode_e;

  localparam int unsigned FLT_MAX_LEN = 8;
  localparam int unsigned FLT_CNT_W   = $clog2(FLT_MAX_LEN);
endpackage

// File: rtl/pwmclr_trig_filter.sv
module pwmclr_trig_filter
  import pwmclr_pkg::*;
#(
  parameter int unsigned SMP_STAGES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic       pol_i,
  input  logic [1:0] sel_i,
  output logic       filt_o
);
  logic [SMP_STAGES-1:0]  smp_q;
  logic                   smp;
  logic [FLT_CNT_W-1:0]   run_q, run_d;
  logic                   filt_q, filt_d;
  logic [FLT_CNT_W-1:0]   len_m1;

  // sampling chain, length picked by parameter
  generate
    for (genvar s = 0; s < SMP_STAGES; s++) begin : g_smp
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) smp_q[0] <= 1'b0;
          else        smp_q[0] <= trig_i ^ pol_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) smp_q[s] <= 1'b0;
          else        smp_q[s] <= smp_q[s-1];
        end
      end
    end
  endgenerate

  assign smp    = smp_q[SMP_STAGES-1];
  assign len_m1 = FLT_CNT_W'((4'd1 << sel_i) - 4'd1);

  always_comb begin
    run_d  = run_q;
    filt_d = filt_q;
    if (smp == filt_q) begin
      run_d = '0;
    end else if (run_q == len_m1) begin
      run_d  = '0;
      filt_d = smp;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // a change of the filtered level always adopts the sampled level
  assert_filt_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(smp)));
endmodule

// File: rtl/pwmclr_counter.sv
module pwmclr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = en_i && (cnt_q == arr_i);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign upd_o = wrap;

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> (cnt_q == '0));
  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !upd_o) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwmclr_ref_gen.sv
module pwmclr_ref_gen
  import pwmclr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic [2:0]       mode_i,
  input  logic             clr_en_i,
  input  logic             trig_f_i,
  output logic             ref_o
);
  ref_mode_e mode;
  logic      match, below, forced, trig_act;
  logic      oc_q, oc_d;
  logic      hold_q, hold_d;
  logic      raw;

  assign mode     = ref_mode_e'(mode_i);
  assign match    = en_i && (cnt_i == ccr_i);
  assign below    = cnt_i < ccr_i;
  assign forced   = (mode == MODE_FLOW) || (mode == MODE_FHIGH);
  assign trig_act = clr_en_i && trig_f_i && !forced;

  always_comb begin
    oc_d = oc_q;
    case (mode)
      MODE_SET:    if (match) oc_d = 1'b1;
      MODE_CLR:    if (match) oc_d = 1'b0;
      MODE_TOGGLE: if (match) oc_d = !oc_q;
      MODE_FLOW:   oc_d = 1'b0;
      MODE_FHIGH:  oc_d = 1'b1;
      default:     oc_d = oc_q;
    endcase
  end

  // update event releases the hold, an active trigger in that cycle re-arms it
  always_comb begin
    if (upd_i) hold_d = trig_act;
    else       hold_d = hold_q || trig_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      oc_q   <= oc_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    case (mode)
      MODE_PWM1:  raw = below;
      MODE_PWM2:  raw = !below;
      MODE_FLOW:  raw = 1'b0;
      MODE_FHIGH: raw = 1'b1;
      default:    raw = oc_q;
    endcase
  end

  assign ref_o = raw && (forced || !(hold_q || trig_act));

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !upd_i) |=> hold_q);
  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && trig_act) |=> hold_q);
  assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !forced) |-> !ref_o);
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOGGLE && match) |=> (oc_q != $past(oc_q)));
endmodule

// File: rtl/pwmclr_channel.sv
module pwmclr_channel
  import pwmclr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SMP_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic [2:0]       mode_i,
  input  logic             clr_en_i,
  input  logic             trig_pol_i,
  input  logic [1:0]       flt_sel_i,
  input  logic             trig_i,
  output logic             ref_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt;
  logic             upd;
  logic             filt;

  pwmclr_trig_filter #(.SMP_STAGES(SMP_STAGES)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .pol_i  (trig_pol_i),
    .sel_i  (flt_sel_i),
    .filt_o (filt)
  );

  pwmclr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cnt_en_i),
    .arr_i (arr_i),
    .cnt_o (cnt),
    .upd_o (upd)
  );

  pwmclr_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (cnt_en_i),
    .cnt_i    (cnt),
    .upd_i    (upd),
    .ccr_i    (ccr_i),
    .mode_i   (mode_i),
    .clr_en_i (clr_en_i),
    .trig_f_i (filt),
    .ref_o    (ref_o)
  );

  assign upd_o = upd;

  assert_trig_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && filt && mode_i != MODE_FLOW && mode_i != MODE_FHIGH) |-> !ref_o);
  assert_force_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FHIGH) |-> ref_o);
  assert_force_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FLOW) |-> !ref_o);
endmodule

// File: tb/tb_pwmclr_channel.sv
module tb_pwmclr_channel;
  localparam logic [2:0] M_FROZEN = 3'd0, M_SET = 3'd1, M_TOG = 3'd3,
                         M_FLOW = 3'd4, M_FHIGH = 3'd5, M_PWM1 = 3'd6, M_PWM2 = 3'd7;

  // {arr, ccr, mode}
  localparam logic [34:0] VEC [0:6] = '{
    {16'd9,  16'd4,  M_PWM1},
    {16'd9,  16'd4,  M_PWM2},
    {16'd7,  16'd0,  M_PWM1},
    {16'd7,  16'd8,  M_PWM1},
    {16'd0,  16'd1,  M_PWM1},
    {16'd15, 16'd15, M_PWM2},
    {16'd3,  16'd1,  M_PWM1}
  };

  logic        clk = 1'b0;
  logic        rst_n, cnt_en, clr_en, pol, trig;
  logic [15:0] arr, ccr;
  logic [2:0]  mode;
  logic [1:0]  flt;
  logic        ref_o, upd_o;
  int          total = 0, bad = 0, m_cnt = 0;

  always #2 clk = ~clk;

  pwmclr_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .arr_i(arr), .ccr_i(ccr),
    .mode_i(mode), .clr_en_i(clr_en), .trig_pol_i(pol), .flt_sel_i(flt),
    .trig_i(trig), .ref_o(ref_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b (cnt=%0d)", req, act, exp, m_cnt);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (cnt_en) m_cnt = (m_cnt == int'(arr)) ? 0 : m_cnt + 1;
    @(negedge clk);
  endtask

  task automatic run_to(input int c);
    while (m_cnt != c) step();
  endtask

  task automatic do_reset(input int a, input int c, input logic [2:0] m,
                          input logic ce, input logic p, input logic [1:0] f, input logic t);
    @(negedge clk);
    rst_n = 1'b0;
    arr = 16'(a); ccr = 16'(c); mode = m; clr_en = ce; pol = p; flt = f; trig = t;
    cnt_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; clr_en = 1'b0; pol = 1'b0; trig = 1'b0;
    arr = '0; ccr = '0; mode = M_PWM1; flt = 2'd0;

    // R11: reset state
    @(negedge clk);
    arr = 16'd5; ccr = 16'd3; mode = M_PWM1;
    @(negedge clk);
    chk("R11 upd in reset", upd_o, 1'b0);
    chk("R11 pwm ref in reset", ref_o, 1'b1);
    mode = M_SET;
    @(negedge clk);
    chk("R11 oc level in reset", ref_o, 1'b0);

    // R1/R2: vector table of PWM patterns
    for (int v = 0; v < 7; v++) begin
      do_reset(int'(VEC[v][34:19]), int'(VEC[v][18:3]), VEC[v][2:0], 1'b0, 1'b0, 2'd0, 1'b0);
      for (int k = 0; k < 2 * (int'(arr) + 1); k++) begin
        logic e;
        e = (m_cnt < int'(ccr));
        if (mode == M_PWM2) e = !e;
        chk("R2 pwm level", ref_o, e);
        chk("R1 update event", upd_o, (m_cnt == int'(arr)));
        step();
      end
    end

    // R1: counter enable low holds and masks update
    do_reset(4, 2, M_PWM1, 1'b0, 1'b0, 2'd0, 1'b0);
    run_to(4);
    chk("R1 upd at top", upd_o, 1'b1);
    cnt_en = 1'b0;
    #0;
    chk("R1 upd masked", upd_o, 1'b0);
    step(); step();
    chk("R1 hold while off", ref_o, 1'b0);
    chk("R1 no upd while off", upd_o, 1'b0);
    cnt_en = 1'b1;
    #0;
    chk("R1 upd resumes", upd_o, 1'b1);
    step();
    chk("R1 wrap after resume", ref_o, 1'b1);

    // R3: toggle and set on match
    do_reset(4, 2, M_TOG, 1'b0, 1'b0, 2'd0, 1'b0);
    run_to(2); chk("R3 toggle before match", ref_o, 1'b0);
    step();    chk("R3 toggle after match", ref_o, 1'b1);
    run_to(2); chk("R3 toggle held", ref_o, 1'b1);
    step();    chk("R3 toggle back", ref_o, 1'b0);
    do_reset(4, 3, M_SET, 1'b0, 1'b0, 2'd0, 1'b0);
    run_to(3); chk("R3 set before match", ref_o, 1'b0);
    step();    chk("R3 set after match", ref_o, 1'b1);
    mode = M_FROZEN;
    step(); step(); step(); step(); step();
    chk("R3 frozen holds", ref_o, 1'b1);

    // R5/R6: clear, hold after trigger drops, release at update
    do_reset(9, 10, M_PWM1, 1'b1, 1'b0, 2'd0, 1'b0);
    run_to(2);
    trig = 1'b1;
    step(); chk("R5 filter latency", ref_o, 1'b1);
    step(); chk("R5 cleared", ref_o, 1'b0);
    trig = 1'b0;
    step(); step(); step();
    chk("R6 held after drop", ref_o, 1'b0);
    run_to(9); chk("R6 held to top", ref_o, 1'b0);
    step();    chk("R6 released at update", ref_o, 1'b1);

    // R7: trigger active across the update event
    run_to(7);
    trig = 1'b1;
    step(); step();
    chk("R7 cleared before wrap", ref_o, 1'b0);
    step();
    chk("R7 low after wrap", ref_o, 1'b0);
    trig = 1'b0;
    run_to(5); chk("R7 rearmed hold", ref_o, 1'b0);
    run_to(9); chk("R7 held to top", ref_o, 1'b0);
    step();    chk("R7 released next wrap", ref_o, 1'b1);

    // R8: clear disabled
    do_reset(9, 10, M_PWM1, 1'b0, 1'b0, 2'd0, 1'b0);
    trig = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step();
      chk("R8 no effect when disabled", ref_o, 1'b1);
    end

    // R4: forced modes ignore the trigger
    do_reset(9, 3, M_FHIGH, 1'b1, 1'b0, 2'd0, 1'b1);
    for (int k = 0; k < 12; k++) begin
      step();
      chk("R4 force high", ref_o, 1'b1);
    end
    mode = M_FLOW;
    step();
    chk("R4 force low", ref_o, 1'b0);

    // R9: active-low polarity
    do_reset(9, 10, M_PWM1, 1'b1, 1'b1, 2'd0, 1'b1);
    step(); step(); step();
    chk("R9 inactive high level", ref_o, 1'b1);
    trig = 1'b0;
    step(); chk("R9 latency", ref_o, 1'b1);
    step(); chk("R9 active low clears", ref_o, 1'b0);

    // R10: filter length 4 (sel=2)
    do_reset(19, 20, M_PWM1, 1'b1, 1'b0, 2'd2, 1'b0);
    run_to(1);
    trig = 1'b1;
    step(); step(); step();
    trig = 1'b0;
    for (int k = 0; k < 14; k++) begin
      chk("R10 short pulse ignored", ref_o, 1'b1);
      step();
    end
    run_to(1);
    trig = 1'b1;
    step(); step(); step(); step();
    trig = 1'b0;
    chk("R10 not yet accepted", ref_o, 1'b1);
    step();
    chk("R10 accepted after N", ref_o, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule